// File: doc/BRIEF.md
# Two-Channel DMA Control and Status Register File

This block is the software-visible register file of a two-channel scatter-gather DMA engine. A processor reaches it through a word-addressed bus that completes in one cycle. Each channel has a control word, a status word, a current-descriptor pointer, a tail-descriptor pointer and a few plain storage words. The block keeps the run/stop, soft-reset, halted and idle state of each channel. It sends a one-cycle start pulse to the descriptor engine whenever software writes a tail pointer, and it drives one registered interrupt line per channel.

The descriptor engine and the interrupt-coalescing counters sit outside this block. The engine reports halt, idle and interrupt-cause events through one-cycle pulses. The counter block supplies the live coalesce count and delay-timer count, and a status read splices both into its upper bytes. Both channels share one bus. The channel is chosen by the address window the access falls in, and windows repeat further up the address space.

Top module: `dmacsr_top`

## Requirements
- R1: An access at byte address A goes to channel ((A / 48) & 1), register index ((A mod 48) >> 2). Index 0 is control, 1 is status, 2 is the current-descriptor pointer and 4 is the tail pointer, so channel 1's control word is at 0x30 and address 0x60 aliases channel 0's control word.
- R2: A read (bus_valid=1, bus_wr=0) places its data on bus_rdata at the clock edge that samples it. bus_rdata then holds that value until the next read.
- R3: Control bit 1 (tail-pointer mode) always reads as 1, whatever was written. All other written control bits read back as written.
- R4: After rst, control reads 0x00010002 and status bits 15:0 read 0x0001 (halted). irq and eng_start are 0.
- R5: A control write with bit 2 set, or any control write while an earlier reset is still pending, reinitialises the channel. Control becomes 0x00010006 and status bits 15:0 become 0x0001, and run (bit 0) is not honoured. The pending reset stays in place until the next control read. That read returns the word with bit 2 already cleared, and the clear takes effect at that read.
- R6: A control write with bit 0 set and no reset requested or pending clears status bit 0 (halted) and bit 1 (idle).
- R7: A tail-pointer write stores the value, clears status bit 1 and makes eng_start for that channel high for exactly the one cycle after the write edge.
- R8: A status read returns {delay count, coalesce count, status bits 15:0}, using the channel's 8-bit dly_cnt and coal_cnt slices at the read edge.
- R9: Status bits 14:12 are interrupt flags. evt_irq bit k of a channel sets status bit 12+k, and writing 1 to a flag bit through a status write clears it. The other status bits 15:0 take the written value.
- R10: irq for a channel equals the OR of (status bits 14:12 AND control bits 14:12). It changes on the same edge as the state that causes it.
- R11: The current-descriptor pointer and every other word without special behaviour read back the last value written to them in that channel. They read 0 if nothing has been written since rst.
- R12: evt_halt sets status bit 0 and evt_idle sets status bit 1. An event wins over a bus write that would clear the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_halt | input | 2 | Per-channel halt event pulse from engine |
| evt_idle | input | 2 | Per-channel idle event pulse from engine |
| evt_irq | input | 6 | Interrupt-cause pulses, 3 per channel (channel c at bits 3c+2:3c) |
| coal_cnt | input | 16 | Live coalesce count, 8 bits per channel |
| dly_cnt | input | 16 | Live delay-timer count, 8 bits per channel |
| eng_start | output | 2 | Per-channel engine start pulse |
| irq | output | 2 | Per-channel masked interrupt |

## Verification
The bench targets the pending soft reset. A second control write before any control read must reinitialise the channel again rather than start it. A design that cleared the reset flag at once would drop halted on that second write. The bench also checks that the reset flag is hidden on the very read that clears it, and that address aliasing lands on the right channel. A wrong divide would send the write to the other channel's control word. Write-one-to-clear flags, the interrupt mask and an event colliding with a status write are each checked at irq and through status readback. An inverted priority would lose the halted bit.

// File: rtl/dmacsr_pkg.sv
package dmacsr_pkg;
  localparam int NCH       = 2;
  localparam int WIN_BYTES = 48;
  localparam int NREG      = WIN_BYTES / 4;
  localparam int IDX_W     = $clog2(NREG);
  localparam int CNT_W     = 8;
  localparam int FLG_W     = 3;
  localparam int FLG_LO    = 12;

  localparam logic [IDX_W-1:0] IDX_CTL  = IDX_W'(0);
  localparam logic [IDX_W-1:0] IDX_STS  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_CUR  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_TAIL = IDX_W'(4);

  localparam int B_RUN  = 0;
  localparam int B_TPM  = 1;
  localparam int B_SRST = 2;
  localparam int B_HALT = 0;
  localparam int B_IDLE = 1;

  localparam logic [31:0] CTL_INIT = 32'h0001_0002;
  localparam logic [31:0] CTL_SRST = 32'h0001_0006;
  localparam logic [15:0] STS_INIT = 16'h0001;
endpackage

// File: rtl/dmacsr_decode.sv
module dmacsr_decode
  import dmacsr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              ch,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    ch  = 1'((addr / ADDR_W'(WIN_BYTES)) & ADDR_W'(1));
    idx = IDX_W'((addr % ADDR_W'(WIN_BYTES)) >> 2);
  end
endmodule

// File: rtl/dmacsr_words.sv
module dmacsr_words
  import dmacsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [IDX_W-1:0] idx,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata
);
  logic [31:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we) begin
      mem[idx] <= wdata;
    end
  end

  always_comb begin
    if (int'(idx) < NREG) rdata = mem[idx];
    else rdata = '0;
  end
endmodule

// File: rtl/dmacsr_chan.sv
module dmacsr_chan
  import dmacsr_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_rd,
  input  logic             sts_wr,
  input  logic             tail_wr,
  input  logic [31:0]      wdata,
  input  logic             evt_halt,
  input  logic             evt_idle,
  input  logic [FLG_W-1:0] evt_irq,
  output logic [31:0]      ctl_q,
  output logic [15:0]      sts_q,
  output logic             start_q,
  output logic             irq_q
);
  logic [31:0] ctl_d;
  logic [15:0] sts_d;

  always_comb begin
    ctl_d = ctl_q;
    sts_d = sts_q;
    if (ctl_rd) ctl_d[B_SRST] = 1'b0;
    if (ctl_wr) begin
      if (wdata[B_SRST] || ctl_q[B_SRST]) begin
        ctl_d = CTL_SRST;
        sts_d = STS_INIT;
      end else begin
        ctl_d = wdata;
        ctl_d[B_TPM] = 1'b1;
        if (wdata[B_RUN]) begin
          sts_d[B_HALT] = 1'b0;
          sts_d[B_IDLE] = 1'b0;
        end
      end
    end
    if (sts_wr) begin
      sts_d = wdata[15:0];
      sts_d[FLG_LO +: FLG_W] = sts_q[FLG_LO +: FLG_W] & ~wdata[FLG_LO +: FLG_W];
    end
    if (tail_wr) sts_d[B_IDLE] = 1'b0;
    if (evt_halt) sts_d[B_HALT] = 1'b1;
    if (evt_idle) sts_d[B_IDLE] = 1'b1;
    sts_d[FLG_LO +: FLG_W] = sts_d[FLG_LO +: FLG_W] | evt_irq;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q   <= CTL_INIT;
      sts_q   <= STS_INIT;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      ctl_q   <= ctl_d;
      sts_q   <= sts_d;
      start_q <= tail_wr;
      irq_q   <= |(sts_d[FLG_LO +: FLG_W] & ctl_d[FLG_LO +: FLG_W]);
    end
  end

  assert_tpm_kept_R3: assert property (@(posedge clk) disable iff (rst)
    ctl_wr |=> ctl_q[B_TPM]);
  assert_srst_init_R5: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && (wdata[B_SRST] || ctl_q[B_SRST])) |=> (ctl_q == CTL_SRST) && sts_q[B_HALT]);
  assert_srst_cleared_on_read_R5: assert property (@(posedge clk) disable iff (rst)
    ctl_rd |=> !ctl_q[B_SRST]);
  assert_run_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl_wr && wdata[B_RUN] && !wdata[B_SRST] && !ctl_q[B_SRST] && !evt_halt && !evt_idle)
      |=> (sts_q[1:0] == 2'b00));
  assert_tail_kick_R7: assert property (@(posedge clk) disable iff (rst)
    (tail_wr && !evt_idle) |=> start_q && !sts_q[B_IDLE]);
  assert_irq_mask_R10: assert property (@(posedge clk) disable iff (rst)
    irq_q == |(sts_q[FLG_LO +: FLG_W] & ctl_q[FLG_LO +: FLG_W]));
  assert_evt_wins_R12: assert property (@(posedge clk) disable iff (rst)
    evt_halt |=> sts_q[B_HALT]);
endmodule

// File: rtl/dmacsr_top.sv
module dmacsr_top
  import dmacsr_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_valid,
  input  logic                   bus_wr,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [31:0]            bus_wdata,
  output logic [31:0]            bus_rdata,
  input  logic [NCH-1:0]         evt_halt,
  input  logic [NCH-1:0]         evt_idle,
  input  logic [NCH*FLG_W-1:0]   evt_irq,
  input  logic [NCH*CNT_W-1:0]   coal_cnt,
  input  logic [NCH*CNT_W-1:0]   dly_cnt,
  output logic [NCH-1:0]         eng_start,
  output logic [NCH-1:0]         irq
);
  logic             ch;
  logic [IDX_W-1:0] idx;
  logic             rd_en, wr_en;
  logic [NCH-1:0]   sel;

  logic [31:0]      ctl_a   [NCH];
  logic [15:0]      sts_a   [NCH];
  logic [31:0]      words_a [NCH];
  logic [CNT_W-1:0] coal_a  [NCH];
  logic [CNT_W-1:0] dly_a   [NCH];

  assign rd_en = bus_valid && !bus_wr;
  assign wr_en = bus_valid && bus_wr;

  dmacsr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .ch(ch), .idx(idx)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign sel[c]    = (ch == 1'(c));
    assign coal_a[c] = coal_cnt[c*CNT_W +: CNT_W];
    assign dly_a[c]  = dly_cnt[c*CNT_W +: CNT_W];

    dmacsr_chan u_chan (
      .clk     (clk),
      .rst     (rst),
      .ctl_wr  (wr_en && sel[c] && idx == IDX_CTL),
      .ctl_rd  (rd_en && sel[c] && idx == IDX_CTL),
      .sts_wr  (wr_en && sel[c] && idx == IDX_STS),
      .tail_wr (wr_en && sel[c] && idx == IDX_TAIL),
      .wdata   (bus_wdata),
      .evt_halt(evt_halt[c]),
      .evt_idle(evt_idle[c]),
      .evt_irq (evt_irq[c*FLG_W +: FLG_W]),
      .ctl_q   (ctl_a[c]),
      .sts_q   (sts_a[c]),
      .start_q (eng_start[c]),
      .irq_q   (irq[c])
    );

    dmacsr_words u_words (
      .clk  (clk),
      .rst  (rst),
      .we   (wr_en && sel[c] && idx != IDX_CTL && idx != IDX_STS),
      .idx  (idx),
      .wdata(bus_wdata),
      .rdata(words_a[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (rd_en) begin
      if (idx == IDX_CTL) begin
        bus_rdata <= ctl_a[ch] & ~(32'd1 << B_SRST);
      end else if (idx == IDX_STS) begin
        bus_rdata <= {dly_a[ch], coal_a[ch], sts_a[ch]};
      end else begin
        bus_rdata <= words_a[ch];
      end
    end
  end

  assert_one_start_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(eng_start));
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(bus_rdata));
  assert_tpm_reads_one_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && idx == IDX_CTL) |=> bus_rdata[B_TPM] && !bus_rdata[B_SRST]);
endmodule

// File: tb/dmacsr_top_tb_top.sv
module dmacsr_top_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  evt_halt = '0;
  logic [1:0]  evt_idle = '0;
  logic [5:0]  evt_irq = '0;
  logic [15:0] coal_cnt = '0;
  logic [15:0] dly_cnt = '0;
  logic [1:0]  eng_start;
  logic [1:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dmacsr_top #(.ADDR_W(8)) dut_i (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_halt(evt_halt), .evt_idle(evt_idle), .evt_irq(evt_irq),
    .coal_cnt(coal_cnt), .dly_cnt(dly_cnt), .eng_start(eng_start), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] v;
    chk("R4 irq after reset", 32'(irq), 32'h0);
    chk("R4 eng_start after reset", 32'(eng_start), 32'h0);
    rd(8'h00, v); chk("R4 ch0 control reset", v, 32'h0001_0002);
    rd(8'h04, v); chk("R4 ch0 status reset", v, 32'h0000_0001);
    rd(8'h34, v); chk("R4 ch1 status reset", v, 32'h0000_0001);
    @(negedge clk); @(negedge clk);
    chk("R2 rdata holds between reads", bus_rdata, 32'h0000_0001);
  endtask

  task automatic t_ctrl;
    logic [31:0] v;
    wr(8'h00, 32'h0000_7000);
    rd(8'h00, v); chk("R3 ch0 control tail mode forced", v, 32'h0000_7002);
    wr(8'h30, 32'hABCD_0000);
    rd(8'h30, v); chk("R3 R1 ch1 control", v, 32'hABCD_0002);
    rd(8'h00, v); chk("R1 ch0 untouched by ch1 write", v, 32'h0000_7002);
    wr(8'h60, 32'h0000_7008);
    rd(8'h00, v); chk("R1 alias 0x60 reaches ch0 control", v, 32'h0000_700A);
    wr(8'h00, 32'h0000_7000);
  endtask

  task automatic t_run;
    logic [31:0] v;
    wr(8'h04, 32'h0000_0003);
    rd(8'h04, v); chk("R9 status plain bits stored", v, 32'h0000_0003);
    wr(8'h00, 32'h0000_7001);
    rd(8'h04, v); chk("R6 run clears halted and idle", v, 32'h0000_0000);
  endtask

  task automatic t_tail;
    logic [31:0] v;
    @(negedge clk); evt_idle = 2'b01;
    @(negedge clk); evt_idle = 2'b00;
    rd(8'h04, v); chk("R12 idle event sets bit1", v, 32'h0000_0002);
    wr(8'h10, 32'h1000_0040);
    chk("R7 start pulse ch0", 32'(eng_start), 32'h1);
    @(negedge clk);
    chk("R7 start pulse one cycle", 32'(eng_start), 32'h0);
    rd(8'h10, v); chk("R7 tail stored", v, 32'h1000_0040);
    rd(8'h04, v); chk("R7 tail write clears idle", v, 32'h0000_0000);
    wr(8'h40, 32'h2000_0000);
    chk("R7 start pulse ch1", 32'(eng_start), 32'h2);
  endtask

  task automatic t_irq;
    logic [31:0] v;
    @(negedge clk); evt_irq = 6'b000_001;
    @(negedge clk); evt_irq = '0;
    chk("R10 irq raised on enabled flag", 32'(irq), 32'h1);
    rd(8'h04, v); chk("R9 flag bit12 set", v, 32'h0000_1000);
    wr(8'h04, 32'h0000_1000);
    chk("R10 irq drops after clear", 32'(irq), 32'h0);
    rd(8'h04, v); chk("R9 write one clears flag", v, 32'h0000_0000);
    wr(8'h00, 32'h0000_2001);
    @(negedge clk); evt_irq = 6'b000_001;
    @(negedge clk); evt_irq = '0;
    chk("R10 masked flag keeps irq low", 32'(irq), 32'h0);
    @(negedge clk); evt_irq = 6'b000_010;
    @(negedge clk); evt_irq = '0;
    chk("R10 enabled bit13 raises irq", 32'(irq), 32'h1);
    wr(8'h04, 32'h0000_0000);
    rd(8'h04, v); chk("R9 write zero keeps flags", v, 32'h0000_3000);
    @(negedge clk);
    bus_valid = 1'b1; bus_wr = 1'b1; bus_addr = 8'h04; bus_wdata = 32'h0000_3000;
    evt_halt = 2'b01;
    @(negedge clk);
    bus_valid = 1'b0; bus_wr = 1'b0; evt_halt = 2'b00;
    rd(8'h04, v); chk("R12 halt event wins over status write", v, 32'h0000_0001);
  endtask

  task automatic t_splice;
    logic [31:0] v;
    coal_cnt = 16'h5A_11; dly_cnt = 16'hC3_22;
    rd(8'h34, v); chk("R8 ch1 status splice", v, 32'hC35A_0001);
    rd(8'h04, v); chk("R8 ch0 status splice", v, 32'h2211_0001);
    coal_cnt = '0; dly_cnt = '0;
  endtask

  task automatic t_srst;
    logic [31:0] v;
    wr(8'h30, 32'h0000_0005);
    rd(8'h34, v); chk("R5 reset write leaves halted", v, 32'h0000_0001);
    wr(8'h30, 32'h0000_0001);
    rd(8'h34, v); chk("R5 pending reset blocks run", v, 32'h0000_0001);
    rd(8'h30, v); chk("R5 control read hides reset bit", v, 32'h0001_0002);
    wr(8'h30, 32'h0000_0001);
    rd(8'h34, v); chk("R5 run works after read", v, 32'h0000_0000);
    rd(8'h30, v); chk("R5 control after release", v, 32'h0000_0003);
  endtask

  task automatic t_words;
    logic [31:0] v;
    rd(8'h3C, v); chk("R11 unwritten word zero", v, 32'h0);
    wr(8'h0C, 32'h1234_5678);
    rd(8'h0C, v); chk("R11 plain word readback", v, 32'h1234_5678);
    rd(8'h3C, v); chk("R11 ch1 word independent", v, 32'h0);
    wr(8'h38, 32'hCAFE_0100);
    rd(8'h38, v); chk("R11 current descriptor readback", v, 32'hCAFE_0100);
    rd(8'h08, v); chk("R11 ch0 current descriptor zero", v, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_run();
    t_tail();
    t_irq();
    t_splice();
    t_srst();
    t_words();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule